// File: doc/BRIEF.md
# Odd-Step Tuning Channel Register

This block keeps the receiver's current channel as a small index and moves it in response to a tuning dial. The index counts 100 kHz increments above the bottom of the band: index 1 is 87.5 MHz and the top index is 212 (108.6 MHz). Only odd indices are ever held. Each dial step moves the held index by two. The even/odd select decides whether the channel sent to the synthesizer is the held index itself or the held index plus one. The plus-one is applied only on the way out, so the held value never changes because of it.

A load port restores a saved channel. Any value it presents is forced onto the nearest lower valid odd index. Four preset slots can each capture the held index on a store strobe and give it back on a recall strobe. The registered effective channel comes with a one-cycle change pulse, so the synthesizer is retuned only when the channel actually moves.

Top module: `chan_step_tuner`

## Requirements
- R1: While reset is asserted and after it is released, `base_idx` is 1, `chan_out` is 1 with `even_sel` low, `chan_chg` is 0, and all four preset slots hold 1.
- R2: `base_idx` is always odd and lies between 1 and 211 inclusive.
- R3: A cycle with `step_up` high and `step_dn` low, with no load or recall, raises `base_idx` by 2 at the next edge. From 211 it wraps to 1.
- R4: A cycle with `step_dn` high and `step_up` low, with no load or recall, lowers `base_idx` by 2 at the next edge. From 1 it wraps to 211.
- R5: If `step_up` and `step_dn` are both high in the same cycle, with no load or recall, `base_idx` does not change.
- R6: One edge after a cycle, `chan_out` equals the new `base_idx` plus 1 if `even_sel` was high in that cycle, and equals the new `base_idx` otherwise. `even_sel` never alters `base_idx`.
- R7: `load_en` has the highest priority. It sets `base_idx` to a cleaned copy of `load_val`: 0 becomes 1, any value of 211 or more becomes 211, an even value from 2 to 210 becomes that value minus 1, and an odd value from 1 to 209 is kept unchanged.
- R8: `store_en` copies the `base_idx` value seen before the edge into the slot chosen by `slot_sel` (0 to 3). A store on its own leaves `base_idx` and `chan_out` unchanged.
- R9: `recall_en` without `load_en` sets `base_idx` to the value held in slot `slot_sel`. Recall has priority over stepping. If store and recall name the same slot in the same cycle, recall reads the old slot value.
- R10: `chan_chg` is 1 in exactly those cycles in which `chan_out` differs from its value in the previous cycle.
- R11: `chan_out` is never 0 and never above 212.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up | input | 1 | Dial step upward, one cycle per detent |
| step_dn | input | 1 | Dial step downward, one cycle per detent |
| even_sel | input | 1 | 1 selects the even channel (held index plus one) |
| load_en | input | 1 | Load `load_val` into the held index |
| load_val | input | 8 | Channel index to restore, cleaned before use |
| store_en | input | 1 | Copy the held index into slot `slot_sel` |
| recall_en | input | 1 | Load slot `slot_sel` into the held index |
| slot_sel | input | 2 | Preset slot number, 0 to 3 |
| base_idx | output | 8 | Held odd index |
| chan_out | output | 8 | Registered effective channel for the synthesizer |
| chan_chg | output | 1 | One-cycle pulse when `chan_out` changes |

## Verification
The bound checker tests the following on every cycle: the odd range of the held index, the up and down step results including both wraps, the hold when both step inputs are high, the plus-one relation between `chan_out` and `base_idx`, the load cleaning of zero and of odd in-range values, the no-effect of a lone store, and the change pulse. Preset storage and recall round trips, the same-slot store/recall ordering, the load cleaning of large and even values, and the reset contents of the slots involve hidden slot state or several operations in sequence. Only the bench's reference model shows those, by checking them over directed sequences and a long random mix of operations.

// File: rtl/chan_tune_pkg.sv
`timescale 1ns/1ps
package chan_tune_pkg;

   // Operation that updates the held index, in falling priority
   typedef enum logic [2:0] {
      OP_HOLD   = 3'd0,
      OP_LOAD   = 3'd1,
      OP_RECALL = 3'd2,
      OP_UP     = 3'd3,
      OP_DOWN   = 3'd4
   } tune_op_e;

endpackage

// File: rtl/tune_op_arbiter.sv
`timescale 1ns/1ps
module tune_op_arbiter
   import chan_tune_pkg::*;
(
   input  logic     load_en,
   input  logic     recall_en,
   input  logic     step_up,
   input  logic     step_dn,
   output tune_op_e op
);

   always_comb begin
      if (load_en)
         op = OP_LOAD;
      else if (recall_en)
         op = OP_RECALL;
      else if (step_up && !step_dn)
         op = OP_UP;
      else if (step_dn && !step_up)
         op = OP_DOWN;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/tune_idx_sanitizer.sv
`timescale 1ns/1ps
module tune_idx_sanitizer #(
   parameter int IDX_W   = 8,
   parameter int TOP_ODD = 211
) (
   input  logic [IDX_W-1:0] raw,
   output logic [IDX_W-1:0] clean
);

   localparam logic [IDX_W-1:0] LOW_IDX  = IDX_W'(1);
   localparam logic [IDX_W-1:0] HIGH_IDX = IDX_W'(TOP_ODD);

   always_comb begin
      if (raw == '0)
         clean = LOW_IDX;
      else if (raw >= HIGH_IDX)
         clean = HIGH_IDX;
      else if (!raw[0])
         clean = raw - LOW_IDX;
      else
         clean = raw;
   end

endmodule

// File: rtl/tune_step_unit.sv
`timescale 1ns/1ps
module tune_step_unit #(
   parameter int IDX_W   = 8,
   parameter int TOP_ODD = 211,
   parameter int STEP    = 2,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic [IDX_W-1:0] cur,
   output logic [IDX_W-1:0] nxt_up,
   output logic [IDX_W-1:0] nxt_dn
);

   localparam logic [IDX_W-1:0] LOW_IDX  = IDX_W'(1);
   localparam logic [IDX_W-1:0] HIGH_IDX = IDX_W'(TOP_ODD);
   localparam logic [IDX_W-1:0] STEP_V   = IDX_W'(STEP);
   localparam logic [IDX_W-1:0] UP_LIM   = IDX_W'(TOP_ODD - STEP);
   localparam logic [IDX_W-1:0] DN_LIM   = IDX_W'(1 + STEP);

   logic top_hit;
   logic bot_hit;

   assign top_hit = (cur > UP_LIM);
   assign bot_hit = (cur < DN_LIM);

   generate
      if (WRAP_EN) begin : g_wrap
         assign nxt_up = top_hit ? LOW_IDX  : cur + STEP_V;
         assign nxt_dn = bot_hit ? HIGH_IDX : cur - STEP_V;
      end else begin : g_sat
         assign nxt_up = top_hit ? cur : cur + STEP_V;
         assign nxt_dn = bot_hit ? cur : cur - STEP_V;
      end
   endgenerate

endmodule

// File: rtl/tune_preset_bank.sv
`timescale 1ns/1ps
module tune_preset_bank #(
   parameter int IDX_W     = 8,
   parameter int NUM_SLOTS = 4,
   parameter int SLOT_W    = 2,
   parameter int RESET_IDX = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] sel,
   input  logic [IDX_W-1:0]  wr_val,
   output logic [IDX_W-1:0]  rd_val
);

   logic [IDX_W-1:0] slot_vals [NUM_SLOTS];

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         logic [IDX_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q <= IDX_W'(RESET_IDX);
            else if (wr_en && (sel == SLOT_W'(g)))
               slot_q <= wr_val;
         end
         assign slot_vals[g] = slot_q;
      end
   endgenerate

   assign rd_val = slot_vals[sel];

endmodule

// File: rtl/tune_out_stage.sv
`timescale 1ns/1ps
module tune_out_stage #(
   parameter int IDX_W     = 8,
   parameter int RESET_IDX = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] nxt_base,
   input  logic             even_sel,
   output logic [IDX_W-1:0] chan_out,
   output logic             chan_chg
);

   logic [IDX_W-1:0] eff_d;

   assign eff_d = nxt_base + {{(IDX_W-1){1'b0}}, even_sel};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_out <= IDX_W'(RESET_IDX);
         chan_chg <= 1'b0;
      end else begin
         chan_out <= eff_d;
         chan_chg <= (eff_d != chan_out);
      end
   end

endmodule

// File: rtl/chan_step_tuner.sv
`timescale 1ns/1ps
module chan_step_tuner
   import chan_tune_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int IDX_MAX   = 212,
   parameter int STEP      = 2,
   parameter int NUM_SLOTS = 4,
   parameter int RESET_IDX = 1,
   parameter bit WRAP_EN   = 1'b1,
   localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_up,
   input  logic              step_dn,
   input  logic              even_sel,
   input  logic              load_en,
   input  logic [IDX_W-1:0]  load_val,
   input  logic              store_en,
   input  logic              recall_en,
   input  logic [SLOT_W-1:0] slot_sel,
   output logic [IDX_W-1:0]  base_idx,
   output logic [IDX_W-1:0]  chan_out,
   output logic              chan_chg
);

   localparam int TOP_ODD = (IDX_MAX % 2 == 1) ? IDX_MAX : IDX_MAX - 1;

   // Elaboration-time parameter checks
   if (IDX_MAX >= (2 ** IDX_W)) begin : g_chk_width
      $error("IDX_MAX does not fit in IDX_W bits");
   end
   if (IDX_MAX < 3) begin : g_chk_span
      $error("IDX_MAX must be at least 3");
   end
   if ((RESET_IDX % 2 != 1) || (RESET_IDX > TOP_ODD)) begin : g_chk_reset
      $error("RESET_IDX must be odd and within range");
   end
   if ((STEP % 2 != 0) || (STEP < 2) || (STEP > TOP_ODD - 1)) begin : g_chk_step
      $error("STEP must be even, at least 2 and below the span");
   end
   if ((NUM_SLOTS < 2) || ((2 ** SLOT_W) != NUM_SLOTS)) begin : g_chk_slots
      $error("NUM_SLOTS must be a power of two of at least 2");
   end

   tune_op_e         op;
   logic [IDX_W-1:0] cur_q;
   logic [IDX_W-1:0] cur_d;
   logic [IDX_W-1:0] load_clean;
   logic [IDX_W-1:0] up_val;
   logic [IDX_W-1:0] dn_val;
   logic [IDX_W-1:0] slot_val;

   tune_op_arbiter u_arb (
      .load_en   (load_en),
      .recall_en (recall_en),
      .step_up   (step_up),
      .step_dn   (step_dn),
      .op        (op)
   );

   tune_idx_sanitizer #(
      .IDX_W   (IDX_W),
      .TOP_ODD (TOP_ODD)
   ) u_san (
      .raw   (load_val),
      .clean (load_clean)
   );

   tune_step_unit #(
      .IDX_W   (IDX_W),
      .TOP_ODD (TOP_ODD),
      .STEP    (STEP),
      .WRAP_EN (WRAP_EN)
   ) u_step (
      .cur    (cur_q),
      .nxt_up (up_val),
      .nxt_dn (dn_val)
   );

   tune_preset_bank #(
      .IDX_W     (IDX_W),
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W),
      .RESET_IDX (RESET_IDX)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (store_en),
      .sel    (slot_sel),
      .wr_val (cur_q),
      .rd_val (slot_val)
   );

   always_comb begin
      unique case (op)
         OP_LOAD:   cur_d = load_clean;
         OP_RECALL: cur_d = slot_val;
         OP_UP:     cur_d = up_val;
         OP_DOWN:   cur_d = dn_val;
         default:   cur_d = cur_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_q <= IDX_W'(RESET_IDX);
      else
         cur_q <= cur_d;
   end

   tune_out_stage #(
      .IDX_W     (IDX_W),
      .RESET_IDX (RESET_IDX)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt_base (cur_d),
      .even_sel (even_sel),
      .chan_out (chan_out),
      .chan_chg (chan_chg)
   );

   assign base_idx = cur_q;

endmodule

// File: rtl/chan_step_tuner_chk.sv
`timescale 1ns/1ps
module chan_step_tuner_chk #(
   parameter int IDX_W   = 8,
   parameter int IDX_MAX = 212,
   parameter int STEP    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_up,
   input logic             step_dn,
   input logic             even_sel,
   input logic             load_en,
   input logic [IDX_W-1:0] load_val,
   input logic             store_en,
   input logic             recall_en,
   input logic [IDX_W-1:0] base_idx,
   input logic [IDX_W-1:0] chan_out,
   input logic             chan_chg
);

   localparam int TOP_ODD = (IDX_MAX % 2 == 1) ? IDX_MAX : IDX_MAX - 1;
   localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);
   localparam logic [IDX_W-1:0] TOPV = IDX_W'(TOP_ODD);
   localparam logic [IDX_W-1:0] MAXV = IDX_W'(IDX_MAX);
   localparam logic [IDX_W-1:0] STPV = IDX_W'(STEP);

   p_odd_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      base_idx[0] && (base_idx <= TOPV));

   p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !step_dn && !load_en && !recall_en) |=>
      (base_idx == (($past(base_idx) > TOPV - STPV) ? ONE : $past(base_idx) + STPV)));

   p_down_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dn && !step_up && !load_en && !recall_en) |=>
      (base_idx == (($past(base_idx) < ONE + STPV) ? TOPV : $past(base_idx) - STPV)));

   p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && step_dn && !load_en && !recall_en) |=> $stable(base_idx));

   p_even_plus_r6: assert property (@(posedge clk) disable iff (!rst_n)
      even_sel |=> (chan_out == base_idx + ONE));

   p_odd_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !even_sel |=> (chan_out == base_idx));

   p_load_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && load_val[0] && (load_val < TOPV)) |=> (base_idx == $past(load_val)));

   p_load_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && (load_val == '0)) |=> (base_idx == ONE));

   p_store_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (store_en && !load_en && !recall_en && !step_up && !step_dn) |=> $stable(base_idx));

   p_chg_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      chan_chg == (chan_out != $past(chan_out)));

   p_out_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_out != '0) && (chan_out <= MAXV));

endmodule

bind chan_step_tuner chan_step_tuner_chk #(
   .IDX_W   (IDX_W),
   .IDX_MAX (IDX_MAX),
   .STEP    (STEP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step_up   (step_up),
   .step_dn   (step_dn),
   .even_sel  (even_sel),
   .load_en   (load_en),
   .load_val  (load_val),
   .store_en  (store_en),
   .recall_en (recall_en),
   .base_idx  (base_idx),
   .chan_out  (chan_out),
   .chan_chg  (chan_chg)
);

// File: tb/chan_step_tuner_bench.sv
`timescale 1ns/1ps
module chan_step_tuner_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_up = 1'b0, step_dn = 1'b0, even_sel = 1'b0;
   logic       load_en = 1'b0, store_en = 1'b0, recall_en = 1'b0;
   logic [7:0] load_val = '0;
   logic [1:0] slot_sel = '0;
   logic [7:0] base_idx, chan_out;
   logic       chan_chg;

   int checks = 0;
   int errors = 0;
   int m_cur, m_out, m_chg;
   int m_slot [4];

   always #10 clk = ~clk;

   chan_step_tuner u_chan_step_tuner (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .even_sel(even_sel), .load_en(load_en), .load_val(load_val),
      .store_en(store_en), .recall_en(recall_en), .slot_sel(slot_sel),
      .base_idx(base_idx), .chan_out(chan_out), .chan_chg(chan_chg)
   );

   function automatic int clean_idx(int v);
      if (v == 0) return 1;
      if (v >= 211) return 211;
      if (v % 2 == 0) return v - 1;
      return v;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check(tag, "base_idx", int'(base_idx), m_cur);
      check(tag, "chan_out", int'(chan_out), m_out);
      check(tag, "chan_chg", int'(chan_chg), m_chg);
   endtask

   // One cycle: drive at negedge, advance the model, sample after the edge
   task automatic cyc(bit up, bit dn, bit ev, bit ld, int lv, bit st, bit rc, int sel, string tag);
      int nc, prev;
      @(negedge clk);
      step_up = up; step_dn = dn; even_sel = ev; load_en = ld; load_val = 8'(lv);
      store_en = st; recall_en = rc; slot_sel = 2'(sel);
      prev = m_out;
      if (ld) nc = clean_idx(lv);
      else if (rc) nc = m_slot[sel];
      else if (up && !dn) nc = (m_cur == 211) ? 1 : m_cur + 2;
      else if (dn && !up) nc = (m_cur == 1) ? 211 : m_cur - 2;
      else nc = m_cur;
      if (st) m_slot[sel] = m_cur;
      m_cur = nc;
      m_out = nc + int'(ev);
      m_chg = (m_out != prev) ? 1 : 0;
      @(posedge clk);
      #5;
      check_all(tag);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      m_cur = 1; m_out = 1; m_chg = 0;
      foreach (m_slot[i]) m_slot[i] = 1;
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      cyc(0,0,0,0,0,0,0,0,"R1");
      // R1: every slot resets to 1
      for (int s = 0; s < 4; s++) begin
         cyc(0,0,0,1,99,0,0,0,"R7");
         cyc(0,0,0,0,0,0,1,s,"R1");
      end
      // R3: walk up across the whole band and wrap
      cyc(0,0,0,1,1,0,0,0,"R7");
      for (int k = 0; k < 106; k++) cyc(1,0,0,0,0,0,0,0,"R3");
      check("R3", "wrap to 1", int'(base_idx), 1);
      // R4: down wrap from 1 to 211
      cyc(0,1,0,0,0,0,0,0,"R4");
      check("R4", "wrap to 211", int'(base_idx), 211);
      cyc(0,1,0,0,0,0,0,0,"R4");
      // R5: both steps together hold
      cyc(1,1,0,0,0,0,0,0,"R5");
      // R6 and R10: even select toggles output only
      cyc(0,0,1,0,0,0,0,0,"R6");
      cyc(0,0,1,0,0,0,0,0,"R10");
      cyc(1,0,1,1,211,0,0,0,"R6");
      check("R11", "top channel", int'(chan_out), 212);
      cyc(0,0,0,0,0,0,0,0,"R10");
      // R7: load cleaning corners
      cyc(0,0,0,1,0,0,0,0,"R7");
      cyc(0,0,0,1,212,0,0,0,"R7");
      cyc(0,0,0,1,255,0,0,0,"R7");
      cyc(0,0,0,1,100,0,0,0,"R7");
      cyc(1,0,0,1,2,0,1,1,"R7");
      cyc(0,0,0,1,209,0,0,0,"R7");
      // R8 and R9: store, quiet store, recall, same-slot ordering
      cyc(0,0,0,0,0,1,0,2,"R8");
      cyc(0,0,0,1,55,0,0,0,"R7");
      cyc(0,0,0,0,0,1,1,2,"R9");
      cyc(1,0,0,0,0,0,1,2,"R9");
      cyc(0,0,1,0,0,0,1,3,"R9");
      // R2: random mix
      for (int k = 0; k < 3000; k++) begin
         int r = $urandom_range(0, 99);
         bit ld = (r < 8);
         bit rc = (r >= 8 && r < 16);
         bit st = ($urandom_range(0, 9) < 2);
         bit up = ($urandom_range(0, 1) == 1);
         bit dn = ($urandom_range(0, 2) == 0);
         bit ev = (k % 37 < 18);
         cyc(up, dn, ev, ld, $urandom_range(0, 255), st, rc, $urandom_range(0, 3), "R2");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule